// File: doc/BRIEF.md
# Command Queue Pause and End-of-Queue Flag Controller

This block follows the progress of one command queue in an ADC command sequencer and raises two status flags: a pause flag and an end-of-queue flag, each with its own interrupt enable. It runs a small queue state machine with three states: idle, waiting for a trigger, and triggered. The trigger source is set by a mode input, which selects software, gate edge or gate level.

Commands reach the block through a valid/ready handshake. Each command carries a pause bit, an end-of-queue bit and a destination bit, which picks either the on-chip command buffer or the external serial link. After a command is accepted, the transfer stays in flight until the completion strobe for its destination arrives. In level mode, a gate closure that is seen while a transfer is in flight is held until that transfer finishes, and only then does the queue status change.

Software clears the flags through a simple write strobe. A single registered interrupt request combines the two enabled flags. The FIFO, the converter and the serial shifter are outside the block and appear only as handshake signals.

Top module: `cq_flag_ctrl`

## Requirements
- R1: After synchronous reset, both flags are 0, `irq` is 0, `q_state` is 0 (idle) and `cmd_ready` is 0. While `queue_en` is high, the queue moves from idle to waiting (code 1).
- R2: In edge mode (`trig_mode`=1), a rising gate moves a waiting queue to triggered (code 2). When the transfer of an entry with its pause bit set completes, the pause flag sets and the queue returns to waiting. Closing the gate has no effect on the state in this mode.
- R3: In software mode (`trig_mode`=0 or 3), a waiting queue triggers at once. The pause flag never sets, and pause bits have no effect on the state.
- R4: In level mode (`trig_mode`=2), a high gate triggers the queue and pause bits are ignored. A low gate while the queue is triggered and idle of transfers sets the pause flag and moves the queue to waiting on the next clock edge. If a transfer is in flight, the flag and the state change wait for its completion.
- R5: `cmd_ext`=0 sends an entry to the on-chip buffer, which completes on `buf_wr_done`. `cmd_ext`=1 sends it to the serial link, which completes on `ser_done`. The strobe for the other destination is ignored.
- R6: Completing an entry with its end-of-queue bit set sets the end-of-queue flag in every mode, and the queue returns to idle.
- R7: Flags are write-one-to-clear. With `wr_en` high, bit 0 of `wr_data` clears the pause flag and bit 1 clears the end-of-queue flag. A 0 bit leaves its flag as it was.
- R8: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R9: `irq` equals, one cycle late, (pause flag AND `pause_ie`) OR (end-of-queue flag AND `eoq_ie`).
- R10: `cmd_ready` is high only in the triggered state with no transfer in flight and, in level mode, with the gate open. A command is taken in a cycle where both `cmd_valid` and `cmd_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_mode | input | 2 | 0/3 software, 1 edge, 2 level |
| gate_open | input | 1 | Trigger gate level |
| queue_en | input | 1 | Queue enabled; low forces idle |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_pause | input | 1 | Pause bit of the offered command |
| cmd_eoq | input | 1 | End-of-queue bit of the offered command |
| cmd_ext | input | 1 | Destination: 1 serial link, 0 on-chip buffer |
| buf_wr_done | input | 1 | On-chip command buffer write completed |
| ser_done | input | 1 | Serial transmission completed |
| wr_en | input | 1 | Flag clear write strobe |
| wr_data | input | 2 | Clear mask: bit0 pause, bit1 end-of-queue |
| pause_ie | input | 1 | Pause interrupt enable |
| eoq_ie | input | 1 | End-of-queue interrupt enable |
| pause_flag | output | 1 | Pause flag |
| eoq_flag | output | 1 | End-of-queue flag |
| irq | output | 1 | Registered interrupt request |
| q_state | output | 2 | Queue state: 0 idle, 1 waiting, 2 triggered |

## Verification
The assertions assume three things about the inputs. A completion strobe arrives only for a transfer that is in flight. The command source takes no notice of `cmd_ready` going low, since acceptance is judged on the cycle itself. The trigger mode stays fixed while a transfer is in flight. The bench resets the block and picks the mode before each run. It pulses a completion strobe only after a command has been accepted, and the stray opposite strobe it sends lands while that transfer is still in flight, where the design must ignore it.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_SW    = 2'd0;
  localparam logic [MODE_W-1:0] MODE_EDGE  = 2'd1;
  localparam logic [MODE_W-1:0] MODE_LEVEL = 2'd2;

  localparam int NFLAG   = 2;
  localparam int FLAG_PF = 0;
  localparam int FLAG_EQ = 1;

  typedef enum logic [1:0] {
    Q_IDLE = 2'd0,
    Q_WAIT = 2'd1,
    Q_TRIG = 2'd2
  } qstate_t;
endpackage

// File: rtl/cq_seq_fsm.sv
module cq_seq_fsm
  import cq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              gate_open,
  input  logic              queue_en,
  input  logic              acc,
  input  logic              acc_pause,
  input  logic              acc_eoq,
  input  logic              acc_ext,
  input  logic              buf_wr_done,
  input  logic              ser_done,
  output logic              ready,
  output logic              pf_set,
  output logic              eq_set,
  output qstate_t           state
);
  qstate_t state_n;
  logic busy, ext_q, pause_q, eoq_q, gate_q, pend;
  logic is_edge, is_level, is_sw;
  logic done_now, closed, close_apply, pause_done;

  assign is_edge  = (mode == MODE_EDGE);
  assign is_level = (mode == MODE_LEVEL);
  assign is_sw    = !is_edge && !is_level;

  assign done_now    = busy && (ext_q ? ser_done : buf_wr_done);
  assign closed      = is_level && (state == Q_TRIG) && !gate_open;
  assign close_apply = (closed && !busy) || (done_now && (pend || closed));
  assign pause_done  = done_now && pause_q && is_edge;

  assign pf_set = pause_done || (close_apply && is_level);
  assign eq_set = done_now && eoq_q;
  assign ready  = (state == Q_TRIG) && !busy && !closed;

  always_comb begin
    state_n = state;
    if (!queue_en) begin
      state_n = Q_IDLE;
    end else begin
      unique case (state)
        Q_IDLE: state_n = Q_WAIT;
        Q_WAIT: begin
          if (is_sw)                         state_n = Q_TRIG;
          else if (is_edge && gate_open && !gate_q) state_n = Q_TRIG;
          else if (is_level && gate_open)    state_n = Q_TRIG;
        end
        Q_TRIG: begin
          if (eq_set)                          state_n = Q_IDLE;
          else if (pause_done || close_apply)  state_n = Q_WAIT;
        end
        default: state_n = Q_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= Q_IDLE;
      busy    <= 1'b0;
      ext_q   <= 1'b0;
      pause_q <= 1'b0;
      eoq_q   <= 1'b0;
      gate_q  <= 1'b0;
      pend    <= 1'b0;
    end else begin
      state  <= state_n;
      gate_q <= gate_open;
      if (acc) begin
        busy    <= 1'b1;
        ext_q   <= acc_ext;
        pause_q <= acc_pause;
        eoq_q   <= acc_eoq;
      end else if (done_now) begin
        busy <= 1'b0;
      end
      if (done_now || state != Q_TRIG) pend <= 1'b0;
      else if (closed && busy)          pend <= 1'b1;
    end
  end
endmodule

// File: rtl/cq_w1c_flag.sv
module cq_w1c_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= set | (flag & ~clr);
  end
endmodule

// File: rtl/cq_irq_merge.sv
module cq_irq_merge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & enables);
  end
endmodule

// File: rtl/cq_flag_ctrl.sv
module cq_flag_ctrl
  import cq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] trig_mode,
  input  logic              gate_open,
  input  logic              queue_en,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_pause,
  input  logic              cmd_eoq,
  input  logic              cmd_ext,
  input  logic              buf_wr_done,
  input  logic              ser_done,
  input  logic              wr_en,
  input  logic [NFLAG-1:0]  wr_data,
  input  logic              pause_ie,
  input  logic              eoq_ie,
  output logic              pause_flag,
  output logic              eoq_flag,
  output logic              irq,
  output logic [1:0]        q_state
);
  qstate_t            st;
  logic               ready_i, pf_set, eq_set;
  logic [NFLAG-1:0]   set_v, flag_v, ie_v;

  cq_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .mode(trig_mode), .gate_open(gate_open),
    .queue_en(queue_en), .acc(cmd_valid && ready_i),
    .acc_pause(cmd_pause), .acc_eoq(cmd_eoq), .acc_ext(cmd_ext),
    .buf_wr_done(buf_wr_done), .ser_done(ser_done),
    .ready(ready_i), .pf_set(pf_set), .eq_set(eq_set), .state(st)
  );

  assign set_v[FLAG_PF] = pf_set;
  assign set_v[FLAG_EQ] = eq_set;
  assign ie_v[FLAG_PF]  = pause_ie;
  assign ie_v[FLAG_EQ]  = eoq_ie;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    cq_w1c_flag u_flag (
      .clk(clk), .rst(rst), .set(set_v[g]),
      .clr(wr_en && wr_data[g]), .flag(flag_v[g])
    );
  end

  cq_irq_merge #(.N(NFLAG)) u_irq (
    .clk(clk), .rst(rst), .flags(flag_v), .enables(ie_v), .irq(irq)
  );

  assign cmd_ready  = ready_i;
  assign pause_flag = flag_v[FLAG_PF];
  assign eoq_flag   = flag_v[FLAG_EQ];
  assign q_state    = st;
endmodule

// File: rtl/cq_flag_ctrl_chk.sv
module cq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] trig_mode,
  input logic       queue_en,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       cmd_eoq,
  input logic       cmd_ext,
  input logic       buf_wr_done,
  input logic       ser_done,
  input logic       wr_en,
  input logic [1:0] wr_data,
  input logic       pause_ie,
  input logic       eoq_ie,
  input logic       pause_flag,
  input logic       eoq_flag,
  input logic       irq,
  input logic [1:0] q_state
);
  logic in_f, ext_f, eoq_f, done_m;
  assign done_m = in_f && (ext_f ? ser_done : buf_wr_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_f <= 1'b0; ext_f <= 1'b0; eoq_f <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      in_f <= 1'b1; ext_f <= cmd_ext; eoq_f <= cmd_eoq;
    end else if (done_m) begin
      in_f <= 1'b0;
    end
  end

  AST_READY_TRIG: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (q_state == 2'd2 && !in_f));                     // R10
  AST_SW_NO_PAUSE: assert property (@(posedge clk) disable iff (rst)
    ((trig_mode == 2'd0 || trig_mode == 2'd3) && !pause_flag) |=> !pause_flag); // R3
  AST_EOQ_SET: assert property (@(posedge clk) disable iff (rst)
    (done_m && eoq_f) |=> eoq_flag);                               // R6
  AST_PF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pause_flag && !(wr_en && wr_data[0])) |=> pause_flag);         // R7
  AST_IRQ_LAT: assert property (@(posedge clk) disable iff (rst)
    irq == $past((pause_flag && pause_ie) || (eoq_flag && eoq_ie))); // R9
  AST_DEFER: assert property (@(posedge clk) disable iff (rst)
    (trig_mode == 2'd2 && q_state == 2'd2 && in_f && !done_m && queue_en)
      |=> q_state == 2'd2);                                        // R4
endmodule

bind cq_flag_ctrl cq_flag_ctrl_chk u_chk (.*);

// File: tb/tb_cq_flag_ctrl.sv
module tb_cq_flag_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, gate_open, queue_en, cmd_valid, cmd_ready, cmd_pause, cmd_eoq, cmd_ext;
  logic       buf_wr_done, ser_done, wr_en, pause_ie, eoq_ie, pause_flag, eoq_flag, irq;
  logic [1:0] trig_mode, wr_data, q_state;
  int errs = 0, checks = 0;

  cq_flag_ctrl dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic do_reset();
    rst = 1; trig_mode = 0; gate_open = 0; queue_en = 0; cmd_valid = 0;
    cmd_pause = 0; cmd_eoq = 0; cmd_ext = 0; buf_wr_done = 0; ser_done = 0;
    wr_en = 0; wr_data = 0; pause_ie = 1; eoq_ie = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic start_q(int mode);
    trig_mode = mode[1:0]; gate_open = 0; queue_en = 1;
    repeat (2) @(negedge clk);
    if (mode != 0) gate_open = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(bit p, bit e, bit x);
    int n = 0;
    while (!cmd_ready && n < 20) begin @(negedge clk); n++; end
    cmd_valid = 1; cmd_pause = p; cmd_eoq = e; cmd_ext = x;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic pulse_done(bit x);
    if (x) ser_done = 1; else buf_wr_done = 1;
    @(negedge clk);
    ser_done = 0; buf_wr_done = 0;
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    do_reset();
    chk("R1 pause flag", pause_flag, 0);
    chk("R1 eoq flag", eoq_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 state", q_state, 0);
    chk("R1 ready", cmd_ready, 0);
    queue_en = 1; @(negedge clk);
    chk("R1 idle to wait", q_state, 1);

    // sweep modes x pause x eoq x destination
    for (int m = 0; m < 3; m++) begin
      for (int c = 0; c < 8; c++) begin
        bit p = c[0], e = c[1], x = c[2];
        int epf, est, ex;
        do_reset();
        pause_ie = (c < 6); eoq_ie = (c > 1);
        start_q(m);
        chk("R10 ready when triggered", cmd_ready, 1);
        send(p, e, x);
        chk("R10 busy not ready", cmd_ready, 0);
        pulse_done(!x);
        chk("R5 wrong strobe eoq", eoq_flag, 0);
        chk("R5 wrong strobe pause", pause_flag, 0);
        chk("R5 still busy", cmd_ready, 0);
        pulse_done(x);
        epf = (m == 1 && p) ? 1 : 0;
        est = e ? 0 : (epf ? 1 : 2);
        chk(m == 1 ? "R2 pause flag" : (m == 0 ? "R3 pause flag" : "R4 pause flag"), pause_flag, epf);
        chk("R6 eoq flag", eoq_flag, e);
        chk(m == 1 ? "R2 state" : (m == 0 ? "R3 state" : "R4 state"), q_state, est);
        ex = (epf && pause_ie) || (e && eoq_ie);
        @(negedge clk);
        chk("R9 irq", irq, ex);
      end
    end

    // write-one-to-clear
    do_reset(); start_q(1); send(1, 1, 0); pulse_done(0);
    wr_en = 1; wr_data = 2'b00; @(negedge clk); wr_en = 0;
    chk("R7 zero write pause", pause_flag, 1);
    chk("R7 zero write eoq", eoq_flag, 1);
    wr_en = 1; wr_data = 2'b01; @(negedge clk); wr_en = 0;
    chk("R7 clear pause", pause_flag, 0);
    chk("R7 keep eoq", eoq_flag, 1);
    wr_en = 1; wr_data = 2'b10; @(negedge clk); wr_en = 0;
    chk("R7 clear eoq", eoq_flag, 0);

    // set wins over clear
    do_reset(); start_q(1); send(1, 1, 1);
    ser_done = 1; wr_en = 1; wr_data = 2'b11;
    @(negedge clk);
    ser_done = 0; wr_en = 0;
    chk("R8 eoq set wins", eoq_flag, 1);
    chk("R8 pause set wins", pause_flag, 1);

    // edge mode ignores gate closure
    do_reset(); start_q(1);
    gate_open = 0; repeat (2) @(negedge clk);
    chk("R2 gate close ignored", q_state, 2);
    chk("R2 no pause on close", pause_flag, 0);

    // level mode immediate closure
    do_reset(); start_q(2);
    chk("R4 level triggered", q_state, 2);
    gate_open = 0; @(negedge clk);
    chk("R4 immediate pause", pause_flag, 1);
    chk("R4 immediate wait", q_state, 1);

    // level mode deferred closure, serial and on-chip
    for (int x = 0; x < 2; x++) begin
      do_reset(); start_q(2); send(0, 0, x[0]);
      gate_open = 0; repeat (3) @(negedge clk);
      chk("R4 deferred state", q_state, 2);
      chk("R4 deferred no flag", pause_flag, 0);
      pulse_done(x[0]);
      chk("R4 applied flag", pause_flag, 1);
      chk("R4 applied state", q_state, 1);
    end

    // reserved mode behaves as software
    do_reset(); start_q(3); send(1, 0, 0); pulse_done(0);
    chk("R3 reserved no pause", pause_flag, 0);
    chk("R3 reserved state", q_state, 2);

    report();
  end
endmodule